// File: doc/BRIEF.md
# Pre-decode to Instruction Queue Stage

This stage sits between instruction fetch and the decoders. Each cycle it may take one aligned 16-byte fetch line whose per-byte instruction-start marks, length-changing-prefix marks and branch marks have already been worked out upstream. It pulls the instructions out of the line in ascending byte order and writes them into an 18-entry circular instruction queue. Each entry holds the instruction address, its byte length and two property bits.

At most six instructions go into the queue per cycle. A denser line is held and spread over several cycles, and the following line waits until the held line has been fully written. Every instruction that carries a length-changing prefix adds a three-cycle bubble before the line's first write. The decoders see the five oldest entries on parallel lanes and report how many they consumed. A flush input discards the queue and any half-written line.

A start-offset input gives the byte at which a branch target enters the line. Marks below that byte are dropped. The queue never receives a partial group: if the next group of up to six does not fit in the free space, nothing is written that cycle.

Top module: `pdq_top`

## Requirements
- R1: When no line is held and flush is low, the fetch port is ready. A line is accepted on a cycle where both valid and ready are high, at most one line per cycle. The first instructions of an accepted line are visible on the decoder lanes after the second rising edge counted from the accept edge.
- R2: No more than 6 instructions are written per cycle. A line with N instructions and no prefix penalty is written over ceil(N/6) consecutive cycles (for example, 7 instructions take 2 cycles), lowest byte offset first.
- R3: While a held line still has more than 6 instructions left, is in a prefix bubble, or cannot write its final group, the fetch port is not ready. A new line is accepted in the same cycle as the held line's final write.
- R4: Each instruction whose start byte has its prefix mark set adds 3 cycles before the line's first write. No instruction is written during these cycles.
- R5: Start marks at byte positions below the start offset are ignored. They produce no entries, add no prefix penalty, and do not shorten any length.
- R6: A group is written only when the free space at the start of the cycle, counted before that cycle's reads, holds the whole group. If it does not, nothing is written and the group is retried on the next cycle.
- R7: The queue holds up to 18 entries and never loses or duplicates an entry.
- R8: Each entry carries: address = {line index, 4-bit byte offset}; length = distance in bytes to the next accepted start in the line, or to byte 16 for the last instruction; a branch bit and a prefix bit taken from the marks at the start byte.
- R9: Lane k (k = 0..4) shows the k-th oldest entry, and its valid bit is high exactly when the queue holds more than k entries. A take count removes that many oldest entries at the clock edge and is clamped to the number of valid lanes.
- R10: When flush is high, the fetch port is not ready, and after that edge the queue is empty and no line is held.
- R11: After reset the queue is empty, no lane is valid and the fetch port is ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| flush_i | input | 1 | Discard queue contents and any held line |
| line_valid_i | input | 1 | Fetch line present |
| line_ready_o | output | 1 | Fetch line accepted this cycle when valid |
| line_idx_i | input | ADDR_W-4 (28) | Aligned line address, upper bits |
| line_ofs_i | input | 4 | Byte offset where execution enters the line |
| line_start_i | input | 16 | Per-byte instruction start marks |
| line_br_i | input | 16 | Per-byte branch marks (valid at start bytes) |
| line_lcp_i | input | 16 | Per-byte length-changing-prefix marks (valid at start bytes) |
| dec_valid_o | output | 5 | Lane valid, thermometer coded from lane 0 |
| dec_pc_o | output | 5*ADDR_W (160) | Lane addresses, lane k at bits k*32 upward |
| dec_len_o | output | 5*5 (25) | Lane instruction lengths |
| dec_br_o | output | 5 | Lane branch bits |
| dec_lcp_o | output | 5 | Lane prefix bits |
| dec_take_i | input | 3 | Number of lanes consumed this cycle |

## Verification
The bench uses the default parameters: 16-byte lines, 6 writes per cycle, 18 entries, 5 read lanes and a 3-cycle prefix penalty. With these values a full line of 16 starts needs three write cycles, and two such lines overflow the queue. This brings into reach the case where a final group is blocked for lack of space while an earlier group of the same line was already written. A take width of three bits lets the bench request 6 or 7 lanes, which exercises the clamp to the five lanes and to the current fill.

// File: rtl/pdq_pkg.sv
package pdq_pkg;
  typedef enum logic [1:0] {
    PH_IDLE,
    PH_STALL,
    PH_EMIT
  } line_phase_e;

  function automatic int unsigned umin(input int unsigned a, input int unsigned b);
    return (a < b) ? a : b;
  endfunction
endpackage

// File: rtl/pdq_extract.sv
module pdq_extract #(
  parameter int LINE_BYTES = 16,
  parameter int WR_MAX     = 6,
  parameter int ADDR_W     = 32,
  localparam int OFS_W = $clog2(LINE_BYTES),
  localparam int LEN_W = $clog2(LINE_BYTES + 1),
  localparam int CNT_W = $clog2(LINE_BYTES + 1),
  localparam int EW    = ADDR_W + LEN_W + 2
) (
  input  logic [ADDR_W-OFS_W-1:0]     base_i,
  input  logic [LINE_BYTES-1:0]       mask_i,
  input  logic [LINE_BYTES-1:0]       starts_i,
  input  logic [LINE_BYTES-1:0]       br_i,
  input  logic [LINE_BYTES-1:0]       lcp_i,
  output logic [CNT_W-1:0]            cnt_o,
  output logic [LINE_BYTES-1:0]       taken_o,
  output logic [WR_MAX-1:0][EW-1:0]   ent_o
);
  logic [LINE_BYTES-1:0][LEN_W-1:0] len_a;

  // length = distance to next start, or to end of line
  always_comb begin
    int nxt;
    nxt = LINE_BYTES;
    for (int i = LINE_BYTES - 1; i >= 0; i--) begin
      len_a[i] = LEN_W'(nxt - i);
      if (starts_i[i]) nxt = i;
    end
  end

  // pick the lowest WR_MAX remaining starts, in byte order
  always_comb begin
    int k;
    int tot;
    k       = 0;
    tot     = 0;
    ent_o   = '0;
    taken_o = '0;
    for (int i = 0; i < LINE_BYTES; i++) begin
      if (mask_i[i]) begin
        tot = tot + 1;
        if (k < WR_MAX) begin
          ent_o[k]   = {base_i, OFS_W'(i), len_a[i], br_i[i], lcp_i[i]};
          taken_o[i] = 1'b1;
          k = k + 1;
        end
      end
    end
    cnt_o = CNT_W'(tot);
  end
endmodule

// File: rtl/pdq_line_ctl.sv
module pdq_line_ctl
  import pdq_pkg::*;
#(
  parameter int LINE_BYTES = 16,
  parameter int WR_MAX     = 6,
  parameter int LCP_CYC    = 3,
  parameter int ADDR_W     = 32,
  parameter int IQ_DEPTH   = 18,
  localparam int OFS_W  = $clog2(LINE_BYTES),
  localparam int CNT_W  = $clog2(LINE_BYTES + 1),
  localparam int WN_W   = $clog2(WR_MAX + 1),
  localparam int FREE_W = $clog2(IQ_DEPTH + 1),
  localparam int STL_W  = $clog2(LCP_CYC * LINE_BYTES + 1)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      flush_i,
  input  logic                      line_valid_i,
  output logic                      line_ready_o,
  input  logic [ADDR_W-OFS_W-1:0]   line_idx_i,
  input  logic [OFS_W-1:0]          line_ofs_i,
  input  logic [LINE_BYTES-1:0]     line_start_i,
  input  logic [LINE_BYTES-1:0]     line_br_i,
  input  logic [LINE_BYTES-1:0]     line_lcp_i,
  input  logic [CNT_W-1:0]          cnt_i,
  input  logic [LINE_BYTES-1:0]     taken_i,
  input  logic [FREE_W-1:0]         free_i,
  output logic [LINE_BYTES-1:0]     mask_o,
  output logic [LINE_BYTES-1:0]     starts_o,
  output logic [LINE_BYTES-1:0]     br_o,
  output logic [LINE_BYTES-1:0]     lcp_o,
  output logic [ADDR_W-OFS_W-1:0]   base_o,
  output logic [WN_W-1:0]           wr_n_o
);
  logic                    hold_q;
  logic [STL_W-1:0]        stall_q;
  logic [LINE_BYTES-1:0]   mask_q, starts_q, br_q, lcp_q;
  logic [ADDR_W-OFS_W-1:0] base_q;
  line_phase_e             phase;
  int unsigned             grp_n;
  logic                    emit, done, accept;
  logic [LINE_BYTES-1:0]   in_starts;
  logic [STL_W-1:0]        in_stall;

  always_comb begin
    if (!hold_q)            phase = PH_IDLE;
    else if (stall_q != '0) phase = PH_STALL;
    else                    phase = PH_EMIT;
  end

  assign grp_n  = umin(int'(cnt_i), WR_MAX);
  // whole group or nothing
  assign emit   = (phase == PH_EMIT) && (grp_n <= int'(free_i));
  assign done   = emit && (int'(cnt_i) <= WR_MAX);
  assign wr_n_o = emit ? WN_W'(grp_n) : '0;

  assign line_ready_o = !flush_i && (!hold_q || done);
  assign accept       = line_valid_i && line_ready_o;

  assign in_starts = line_start_i & ({LINE_BYTES{1'b1}} << line_ofs_i);
  assign in_stall  = STL_W'(LCP_CYC * $countones(in_starts & line_lcp_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q   <= 1'b0;
      stall_q  <= '0;
      mask_q   <= '0;
      starts_q <= '0;
      br_q     <= '0;
      lcp_q    <= '0;
      base_q   <= '0;
    end else if (flush_i) begin
      hold_q  <= 1'b0;
      stall_q <= '0;
      mask_q  <= '0;
    end else if (accept) begin
      hold_q   <= 1'b1;
      stall_q  <= in_stall;
      mask_q   <= in_starts;
      starts_q <= in_starts;
      br_q     <= line_br_i;
      lcp_q    <= line_lcp_i;
      base_q   <= line_idx_i;
    end else if (done) begin
      hold_q <= 1'b0;
      mask_q <= '0;
    end else if (emit) begin
      mask_q <= mask_q & ~taken_i;
    end else if (phase == PH_STALL) begin
      stall_q <= stall_q - 1'b1;
    end
  end

  assign mask_o   = hold_q ? mask_q : '0;
  assign starts_o = starts_q;
  assign br_o     = br_q;
  assign lcp_o    = lcp_q;
  assign base_o   = base_q;

  AST_HOLD_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_q && int'(cnt_i) > WR_MAX) |-> !line_ready_o); // R3
  AST_NO_PARTIAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_n_o != '0) |-> (int'(wr_n_o) <= int'(free_i))); // R6
  AST_BUBBLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_q && stall_q != '0) |-> (wr_n_o == '0)); // R4
endmodule

// File: rtl/pdq_ring.sv
module pdq_ring
  import pdq_pkg::*;
#(
  parameter int IQ_DEPTH = 18,
  parameter int WR_MAX   = 6,
  parameter int RD_MAX   = 5,
  parameter int EW       = 39,
  localparam int PTR_W  = $clog2(IQ_DEPTH),
  localparam int FREE_W = $clog2(IQ_DEPTH + 1),
  localparam int WN_W   = $clog2(WR_MAX + 1),
  localparam int TK_W   = $clog2(RD_MAX + 1)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      flush_i,
  input  logic [WN_W-1:0]           wr_n_i,
  input  logic [WR_MAX-1:0][EW-1:0] wr_data_i,
  input  logic [TK_W-1:0]           take_i,
  output logic [FREE_W-1:0]         free_o,
  output logic [RD_MAX-1:0]         rd_valid_o,
  output logic [RD_MAX-1:0][EW-1:0] rd_data_o
);
  logic [IQ_DEPTH-1:0][EW-1:0] mem_q;
  logic [PTR_W-1:0]            head_q;
  logic [FREE_W-1:0]           cnt_q;
  int unsigned                 tk;

  function automatic logic [PTR_W-1:0] wrap(input int unsigned a);
    return PTR_W'(a % IQ_DEPTH);
  endfunction

  assign tk     = umin(umin(int'(take_i), int'(cnt_q)), RD_MAX);
  assign free_o = FREE_W'(IQ_DEPTH) - cnt_q;

  for (genvar l = 0; l < RD_MAX; l++) begin : g_lane
    assign rd_valid_o[l] = (l < int'(cnt_q));
    assign rd_data_o[l]  = mem_q[wrap(int'(head_q) + l)];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q <= '0;
      cnt_q  <= '0;
    end else if (flush_i) begin
      head_q <= '0;
      cnt_q  <= '0;
    end else begin
      head_q <= wrap(int'(head_q) + tk);
      cnt_q  <= FREE_W'(int'(cnt_q) - tk + int'(wr_n_i));
    end
  end

  always_ff @(posedge clk_i) begin
    if (!flush_i) begin
      for (int j = 0; j < WR_MAX; j++) begin
        if (j < int'(wr_n_i)) mem_q[wrap(int'(head_q) + int'(cnt_q) + j)] <= wr_data_i[j];
      end
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(cnt_q) <= IQ_DEPTH); // R7
  AST_WR_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(wr_n_i) <= WR_MAX); // R2
  AST_FLUSH_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (cnt_q == '0)); // R10
  AST_LANE_THERMO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((rd_valid_o & (rd_valid_o + 1'b1)) == '0)); // R9
endmodule

// File: rtl/pdq_top.sv
module pdq_top #(
  parameter int LINE_BYTES = 16,
  parameter int WR_MAX     = 6,
  parameter int RD_MAX     = 5,
  parameter int IQ_DEPTH   = 18,
  parameter int LCP_CYC    = 3,
  parameter int ADDR_W     = 32,
  localparam int OFS_W  = $clog2(LINE_BYTES),
  localparam int LEN_W  = $clog2(LINE_BYTES + 1),
  localparam int CNT_W  = $clog2(LINE_BYTES + 1),
  localparam int WN_W   = $clog2(WR_MAX + 1),
  localparam int TK_W   = $clog2(RD_MAX + 1),
  localparam int FREE_W = $clog2(IQ_DEPTH + 1),
  localparam int EW     = ADDR_W + LEN_W + 2
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      flush_i,
  input  logic                      line_valid_i,
  output logic                      line_ready_o,
  input  logic [ADDR_W-OFS_W-1:0]   line_idx_i,
  input  logic [OFS_W-1:0]          line_ofs_i,
  input  logic [LINE_BYTES-1:0]     line_start_i,
  input  logic [LINE_BYTES-1:0]     line_br_i,
  input  logic [LINE_BYTES-1:0]     line_lcp_i,
  output logic [RD_MAX-1:0]         dec_valid_o,
  output logic [RD_MAX*ADDR_W-1:0]  dec_pc_o,
  output logic [RD_MAX*LEN_W-1:0]   dec_len_o,
  output logic [RD_MAX-1:0]         dec_br_o,
  output logic [RD_MAX-1:0]         dec_lcp_o,
  input  logic [TK_W-1:0]           dec_take_i
);
  logic [CNT_W-1:0]            cnt;
  logic [LINE_BYTES-1:0]       taken, mask, starts, br, lcp;
  logic [ADDR_W-OFS_W-1:0]     base;
  logic [FREE_W-1:0]           free;
  logic [WN_W-1:0]             wr_n;
  logic [WR_MAX-1:0][EW-1:0]   ent;
  logic [RD_MAX-1:0][EW-1:0]   rd_data;

  pdq_line_ctl #(
    .LINE_BYTES(LINE_BYTES), .WR_MAX(WR_MAX), .LCP_CYC(LCP_CYC),
    .ADDR_W(ADDR_W), .IQ_DEPTH(IQ_DEPTH)
  ) i_ctl (
    .clk_i, .rst_ni, .flush_i, .line_valid_i, .line_ready_o,
    .line_idx_i, .line_ofs_i, .line_start_i, .line_br_i, .line_lcp_i,
    .cnt_i(cnt), .taken_i(taken), .free_i(free),
    .mask_o(mask), .starts_o(starts), .br_o(br), .lcp_o(lcp),
    .base_o(base), .wr_n_o(wr_n)
  );

  pdq_extract #(
    .LINE_BYTES(LINE_BYTES), .WR_MAX(WR_MAX), .ADDR_W(ADDR_W)
  ) i_extract (
    .base_i(base), .mask_i(mask), .starts_i(starts), .br_i(br), .lcp_i(lcp),
    .cnt_o(cnt), .taken_o(taken), .ent_o(ent)
  );

  pdq_ring #(
    .IQ_DEPTH(IQ_DEPTH), .WR_MAX(WR_MAX), .RD_MAX(RD_MAX), .EW(EW)
  ) i_ring (
    .clk_i, .rst_ni, .flush_i,
    .wr_n_i(wr_n), .wr_data_i(ent), .take_i(dec_take_i),
    .free_o(free), .rd_valid_o(dec_valid_o), .rd_data_o(rd_data)
  );

  for (genvar l = 0; l < RD_MAX; l++) begin : g_out
    assign dec_pc_o[l*ADDR_W +: ADDR_W] = rd_data[l][EW-1 -: ADDR_W];
    assign dec_len_o[l*LEN_W +: LEN_W]  = rd_data[l][LEN_W+1:2];
    assign dec_br_o[l]                  = rd_data[l][1];
    assign dec_lcp_o[l]                 = rd_data[l][0];
  end

  AST_RESET_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (dec_valid_o == '0)); // R11
endmodule

// File: tb/test_pdq_top.sv
module test_pdq_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         flush = 1'b0;
  logic         lv = 1'b0;
  logic         lrdy;
  logic [27:0]  lidx = '0;
  logic [3:0]   lofs = '0;
  logic [15:0]  lst = '0, lbr = '0, llcp = '0;
  logic [4:0]   dv;
  logic [159:0] dpc;
  logic [24:0]  dlen;
  logic [4:0]   dbr, dlcp;
  logic [2:0]   take = '0;

  always #5 clk = ~clk;

  pdq_top i_pdq_top (
    .clk_i(clk), .rst_ni(rst_n), .flush_i(flush), .line_valid_i(lv),
    .line_ready_o(lrdy), .line_idx_i(lidx), .line_ofs_i(lofs),
    .line_start_i(lst), .line_br_i(lbr), .line_lcp_i(llcp),
    .dec_valid_o(dv), .dec_pc_o(dpc), .dec_len_o(dlen),
    .dec_br_o(dbr), .dec_lcp_o(dlcp), .dec_take_i(take)
  );

  typedef struct packed {
    logic [31:0] pc;
    logic [4:0]  len;
    logic        br;
    logic        lcp;
  } ent_t;

  ent_t iq[$];
  ent_t pend[$];
  bit   pend_v;
  int   stall;
  int   checks = 0;
  int   errors = 0;

  function automatic int imin(int a, int b);
    return a < b ? a : b;
  endfunction

  task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
    end
  endtask

  task automatic step(input bit v, input [27:0] idx, input [3:0] ofs, input [15:0] st,
                      input [15:0] br, input [15:0] lc, input [2:0] tk, input bit fl,
                      input string tag, output bit acc);
    bit er;
    int fr;
    @(negedge clk);
    lv = v; lidx = idx; lofs = ofs; lst = st; lbr = br; llcp = lc; take = tk; flush = fl;
    #1;
    fr = 18 - iq.size();
    er = !fl && (!pend_v || (stall == 0 && pend.size() <= 6 && pend.size() <= fr));
    chk(tag, "ready", 64'(lrdy), 64'(er));
    for (int l = 0; l < 5; l++) begin
      chk(tag, $sformatf("lane%0d valid", l), 64'(dv[l]), 64'(l < iq.size()));
      if (l < iq.size()) begin
        chk(tag, $sformatf("lane%0d pc", l), 64'(dpc[l*32 +: 32]), 64'(iq[l].pc));
        chk(tag, $sformatf("lane%0d len", l), 64'(dlen[l*5 +: 5]), 64'(iq[l].len));
        chk(tag, $sformatf("lane%0d br", l), 64'(dbr[l]), 64'(iq[l].br));
        chk(tag, $sformatf("lane%0d lcp", l), 64'(dlcp[l]), 64'(iq[l].lcp));
      end
    end
    acc = v && er;
    @(posedge clk);
    if (fl) begin
      iq.delete(); pend.delete(); pend_v = 0; stall = 0;
    end else begin
      int n;
      int t;
      t = imin(imin(int'(tk), iq.size()), 5);
      repeat (t) void'(iq.pop_front());
      if (pend_v) begin
        if (stall > 0) stall--;
        else begin
          n = imin(pend.size(), 6);
          if (n <= fr) begin
            repeat (n) iq.push_back(pend.pop_front());
            if (pend.size() == 0) pend_v = 0;
          end
        end
      end
      if (acc) begin
        int nl;
        nl = 0;
        pend.delete();
        for (int i = int'(ofs); i < 16; i++) begin
          if (st[i]) begin
            ent_t e;
            int nx;
            nx = 16;
            for (int j = 15; j > i; j--) if (st[j]) nx = j;
            e.pc = {idx, 4'(i)}; e.len = 5'(nx - i); e.br = br[i]; e.lcp = lc[i];
            if (lc[i]) nl++;
            pend.push_back(e);
          end
        end
        stall = 3 * nl; pend_v = 1;
      end
    end
  endtask

  task automatic send(input [27:0] idx, input [3:0] ofs, input [15:0] st, input [15:0] br,
                      input [15:0] lc, input [2:0] tk, input string tag);
    bit a;
    a = 0;
    for (int i = 0; i < 200 && !a; i++) step(1, idx, ofs, st, br, lc, tk, 0, tag, a);
  endtask

  task automatic idle(input int n, input [2:0] tk, input string tag);
    bit a;
    for (int i = 0; i < n; i++) step(0, '0, '0, '0, '0, '0, tk, 0, tag, a);
  endtask

  task automatic summary;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog act=running exp=finished");
    summary();
    $finish;
  end

  initial begin
    bit a;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    idle(1, 0, "R11");
    // three instructions, lengths 3,5,8, one branch
    send(28'h100, 0, 16'h0101 | 16'h0008, 16'h0100, 16'h0000, 0, "R8");
    idle(2, 0, "R1");
    idle(2, 7, "R9");
    // seven instructions: two write cycles
    send(28'h101, 0, 16'h7F00, 16'h4000, 0, 0, "R2");
    idle(3, 0, "R2");
    // full line of 16 with 7 queued: last group blocked for space
    send(28'h102, 0, 16'hFFFF, 16'h8001, 0, 0, "R6");
    idle(4, 0, "R7");
    idle(3, 2, "R6");
    idle(6, 5, "R9");
    // prefix penalty: two marked starts -> 6 bubble cycles
    send(28'h103, 0, 16'h1111, 0, 16'h0110, 5, "R4");
    idle(10, 5, "R4");
    // offset: starts below byte 6 ignored, including a marked prefix
    send(28'h104, 6, 16'h4943, 16'h0040, 16'h0001, 5, "R5");
    idle(4, 5, "R5");
    // back-to-back lines, second held until first finishes
    send(28'h105, 0, 16'hFFF0, 0, 0, 5, "R3");
    send(28'h106, 0, 16'h0011, 0, 0, 5, "R3");
    send(28'h107, 0, 16'h0101, 0, 0, 5, "R1");
    idle(6, 5, "R1");
    // flush mid-line
    send(28'h108, 0, 16'hFFFF, 0, 0, 0, "R10");
    step(0, '0, '0, '0, '0, '0, 0, 1, "R10", a);
    step(1, 28'h109, 0, 16'h0003, 0, 0, 0, 1, "R10", a);
    idle(3, 0, "R10");
    idle(2, 7, "R9");
    // random traffic
    for (int c = 0; c < 600; c++) begin
      logic [15:0] s, l;
      s = 16'($urandom);
      l = 16'($urandom) & 16'($urandom) & 16'($urandom);
      step(($urandom % 4) != 0, 28'($urandom), 4'($urandom % 3 == 0 ? $urandom : 0), s,
           16'($urandom), l, 3'($urandom), ($urandom % 97) == 0, "R2", a);
    end
    idle(30, 5, "R7");
    summary();
    $finish;
  end
endmodule